// File: doc/BRIEF.md
# Floating-Point Register Stack

This block holds the eight 80-bit registers of a floating-point unit and presents them as a stack. Registers are named st(0) to st(7) relative to a 3-bit top pointer: st(i) lives in physical slot (top + i) mod 8. Each physical slot carries a 2-bit tag that says whether it is empty or holds data. Register contents are opaque words. The block does no arithmetic.

A controller issues one command per clock on `cmd`. It may push a value, pop once or twice, overwrite st(i), swap st(0) with st(i), rotate the pointer in either direction, free a slot or initialize the stack. The values of st(0) and st(idx) are read combinationally. Status outputs show the pointer and the packed tag word. Overflow and underflow are reported on one-cycle flags in the cycle after the command that caused them.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset, and in the cycle after an initialize command (cmd=9), the pointer is 0, every tag is 11 (empty) and both flags are low.
- R2: A push (cmd=1) onto an empty target slot moves the pointer down by one modulo 8. It places `wdata` in the new st(0), so each former st(k) becomes st(k+1). The slot's tag becomes 01 if the value is all zeros and 00 otherwise.
- R3: A push whose target slot (top-1 mod 8) is not empty raises `ovf_o` for exactly the following cycle and leaves the pointer, the tags and the data unchanged.
- R4: A pop (cmd=2) with a non-empty st(0) sets that slot's tag to 11 and moves the pointer up by one. With an empty st(0) it raises `unf_o` and changes nothing.
- R5: A double pop (cmd=3) needs both st(0) and st(1) to be non-empty. It then empties both slots and moves the pointer up by two. Otherwise it raises `unf_o` and changes nothing.
- R6: A write (cmd=4) stores `wdata` in st(idx) and sets that slot's tag to 01 (value zero) or 00 (value non-zero). The pointer is unchanged and no flag is raised.
- R7: An exchange (cmd=5) swaps the data and the tags of st(0) and st(idx). If either of the two is empty, it raises `unf_o` and changes nothing.
- R8: Pointer increment (cmd=6) and decrement (cmd=7) change the pointer by +1 and -1 modulo 8. They leave the tags and the data unchanged.
- R9: A free command (cmd=10) sets the tag of st(idx) to 11 and leaves the pointer unchanged.
- R10: `tagw_o` packs the tag of physical slot p into bits 2p+1:2p.
- R11: `st0_o` and `sti_o` show st(0) and st(idx) combinationally, with no clock edge needed after `idx` changes. Command 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 4 | Command code for this cycle |
| idx | input | 3 | Relative register index i |
| wdata | input | 80 | Value for push and write |
| st0_o | output | 80 | Contents of st(0) |
| sti_o | output | 80 | Contents of st(idx) |
| top_o | output | 3 | Top-of-stack pointer |
| tagw_o | output | 16 | Packed tags, slot 0 in the low bits |
| ovf_o | output | 1 | Stack overflow flag, one cycle |
| unf_o | output | 1 | Stack underflow flag, one cycle |

## Verification
The bench fills all eight slots and pushes once more. A design that compared against the wrong slot would either overwrite live data or drop the pointer. A double pop with only st(0) valid catches a design that checks only one of the two slots and leaves the stack half popped. Pointer rotation is driven through the 7-to-0 wrap, and the bench confirms that the tag word does not move. A design that shifted data, or that tied the tags to relative names, would show a changed tag word there. An exchange with an empty partner must leave everything in place, which exposes a swap done without the empty check.

// File: rtl/fp_reg_stack.sv
module fp_reg_stack #(
  parameter int DW   = 80,
  parameter int NREG = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            cmd,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         st0_o,
  output logic [DW-1:0]         sti_o,
  output logic [$clog2(NREG)-1:0] top_o,
  output logic [2*NREG-1:0]     tagw_o,
  output logic                  ovf_o,
  output logic                  unf_o
);
  localparam int PW = $clog2(NREG);
  localparam logic [1:0] T_VALID = 2'b00, T_ZERO = 2'b01, T_EMPTY = 2'b11;
  localparam logic [3:0] C_NOP = 4'd0, C_PUSH = 4'd1, C_POP = 4'd2, C_POP2 = 4'd3,
                         C_WR = 4'd4, C_XCH = 4'd5, C_INC = 4'd6, C_DEC = 4'd7,
                         C_INIT = 4'd9, C_FREE = 4'd10;

  logic [DW-1:0] regs [NREG];
  logic [1:0]    tags [NREG];
  logic [PW-1:0] top;

  // slot indices wrap because NREG is a power of two
  logic [PW-1:0] p1, pi, pm;
  assign p1 = top + PW'(1);
  assign pi = top + idx;
  assign pm = top - PW'(1);

  logic [1:0] wtag;
  assign wtag = (wdata == '0) ? T_ZERO : T_VALID;

  assign st0_o = regs[top];
  assign sti_o = regs[pi];
  assign top_o = top;

  for (genvar g = 0; g < NREG; g++) begin : g_tw
    assign tagw_o[2*g +: 2] = tags[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top   <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      for (int k = 0; k < NREG; k++) begin
        tags[k] <= T_EMPTY;
        regs[k] <= '0;
      end
    end else begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      case (cmd)
        C_PUSH:
          if (tags[pm] != T_EMPTY) ovf_o <= 1'b1;
          else begin
            top      <= pm;
            regs[pm] <= wdata;
            tags[pm] <= wtag;
          end
        C_POP:
          if (tags[top] == T_EMPTY) unf_o <= 1'b1;
          else begin
            tags[top] <= T_EMPTY;
            top       <= p1;
          end
        C_POP2:
          if (tags[top] == T_EMPTY || tags[p1] == T_EMPTY) unf_o <= 1'b1;
          else begin
            tags[top] <= T_EMPTY;
            tags[p1]  <= T_EMPTY;
            top       <= top + PW'(2);
          end
        C_WR: begin
          regs[pi] <= wdata;
          tags[pi] <= wtag;
        end
        C_XCH:
          if (tags[top] == T_EMPTY || tags[pi] == T_EMPTY) unf_o <= 1'b1;
          else begin
            regs[top] <= regs[pi];
            regs[pi]  <= regs[top];
            tags[top] <= tags[pi];
            tags[pi]  <= tags[top];
          end
        C_INC:  top <= p1;
        C_DEC:  top <= pm;
        C_FREE: tags[pi] <= T_EMPTY;
        C_INIT: begin
          top <= '0;
          for (int k = 0; k < NREG; k++) tags[k] <= T_EMPTY;
        end
        default: ;
      endcase
    end
  end

  // R1
  init_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_INIT |=> top_o == '0 && tagw_o == '1);

  // R3
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PUSH && tags[pm] != T_EMPTY) |=> ovf_o && $stable(top_o) && $stable(tagw_o));

  // R4
  pop_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_POP && tags[top] != T_EMPTY) |=> top_o == PW'($past(top_o) + PW'(1)) && !unf_o);

  // R8
  rot_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_INC |=> top_o == PW'($past(top_o) + PW'(1)) && $stable(tagw_o));

  // R9
  free_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_FREE |=> $stable(top_o) && !ovf_o && !unf_o);

  // R3
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ovf_o && unf_o));
endmodule

// File: tb/sim_fp_reg_stack.sv
module sim_fp_reg_stack;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd = 4'd0;
  logic [2:0]  idx = 3'd0;
  logic [79:0] wdata = '0;
  logic [79:0] st0_o, sti_o;
  logic [2:0]  top_o;
  logic [15:0] tagw_o;
  logic        ovf_o, unf_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  fp_reg_stack u0 (.clk, .rst_n, .cmd, .idx, .wdata, .st0_o, .sti_o,
                   .top_o, .tagw_o, .ovf_o, .unf_o);

  task automatic check(string req, string what, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(logic [3:0] c, logic [2:0] i, logic [79:0] d);
    @(negedge clk);
    cmd = c; idx = i; wdata = d;
    @(posedge clk); #1;
    cmd = 4'd0;
  endtask

  task automatic t_reset;
    check("R1", "top", 80'(top_o), 80'd0);
    check("R1", "tags", 80'(tagw_o), 80'hFFFF);
    check("R1", "flags", 80'({ovf_o, unf_o}), 80'd0);
  endtask

  task automatic t_push;
    op(1, 0, 80'h1234);
    op(1, 0, 80'h5678);
    op(1, 0, 80'h0);
    check("R2", "top", 80'(top_o), 80'd5);
    check("R10", "tags", 80'(tagw_o), 80'h07FF);
    check("R2", "st0", st0_o, 80'h0);
    idx = 3'd1; #1;
    check("R2", "st1", sti_o, 80'h5678);
    idx = 3'd2; #1;
    check("R11", "st2 comb", sti_o, 80'h1234);
  endtask

  task automatic t_xchg;
    op(5, 2, 0);
    check("R7", "st0", st0_o, 80'h1234);
    idx = 3'd2; #1;
    check("R7", "st2", sti_o, 80'h0);
    check("R7", "tags", 80'(tagw_o), 80'h43FF);
    op(5, 3, 0);
    check("R7", "unf", 80'(unf_o), 80'd1);
    check("R7", "tags kept", 80'(tagw_o), 80'h43FF);
    check("R7", "st0 kept", st0_o, 80'h1234);
  endtask

  task automatic t_write;
    op(4, 1, 80'h0);
    check("R6", "tags", 80'(tagw_o), 80'h53FF);
    check("R6", "top", 80'(top_o), 80'd5);
    check("R6", "flags", 80'({ovf_o, unf_o}), 80'd0);
    idx = 3'd1; #1;
    check("R6", "st1", sti_o, 80'h0);
  endtask

  task automatic t_pops;
    op(2, 0, 0);
    check("R4", "top", 80'(top_o), 80'd6);
    check("R4", "tags", 80'(tagw_o), 80'h5FFF);
    op(3, 0, 0);
    check("R5", "top", 80'(top_o), 80'd0);
    check("R5", "tags", 80'(tagw_o), 80'hFFFF);
    op(2, 0, 0);
    check("R4", "unf empty", 80'(unf_o), 80'd1);
    check("R4", "top kept", 80'(top_o), 80'd0);
    op(1, 0, 80'hC0);
    op(3, 0, 0);
    check("R5", "unf half", 80'(unf_o), 80'd1);
    check("R5", "top kept", 80'(top_o), 80'd7);
    check("R5", "tags kept", 80'(tagw_o), 80'h3FFF);
  endtask

  task automatic t_rotate;
    op(7, 0, 0);
    check("R8", "dec top", 80'(top_o), 80'd6);
    check("R8", "dec tags", 80'(tagw_o), 80'h3FFF);
    idx = 3'd1; #1;
    check("R8", "st1 after dec", sti_o, 80'hC0);
    op(6, 0, 0);
    op(6, 0, 0);
    check("R8", "inc wrap", 80'(top_o), 80'd0);
    check("R8", "inc tags", 80'(tagw_o), 80'h3FFF);
    op(7, 0, 0);
    op(0, 0, 80'hDEAD);
    check("R11", "nop top", 80'(top_o), 80'd7);
    check("R11", "nop st0", st0_o, 80'hC0);
  endtask

  task automatic t_free;
    op(10, 0, 0);
    check("R9", "tags", 80'(tagw_o), 80'hFFFF);
    check("R9", "top", 80'(top_o), 80'd7);
  endtask

  task automatic t_overflow;
    op(9, 0, 0);
    check("R1", "init top", 80'(top_o), 80'd0);
    check("R1", "init tags", 80'(tagw_o), 80'hFFFF);
    for (int k = 1; k <= 8; k++) op(1, 0, 80'(k));
    check("R2", "full tags", 80'(tagw_o), 80'h0000);
    check("R2", "full top", 80'(top_o), 80'd0);
    op(1, 0, 80'h99);
    check("R3", "ovf", 80'(ovf_o), 80'd1);
    check("R3", "top kept", 80'(top_o), 80'd0);
    check("R3", "st0 kept", st0_o, 80'd8);
    idx = 3'd7; #1;
    check("R3", "st7 kept", sti_o, 80'd1);
    op(0, 0, 0);
    check("R3", "ovf one cycle", 80'(ovf_o), 80'd0);
    op(9, 0, 0);
    check("R1", "reinit tags", 80'(tagw_o), 80'hFFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    t_reset();
    t_push();
    t_xchg();
    t_write();
    t_pops();
    t_rotate();
    t_free();
    t_overflow();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule